// File: doc/BRIEF.md
# Parallel Bit-Swapped Exhaustive Pattern Generator

This block produces one W-bit test vector on every enabled clock. It is meant for test-per-clock self-test, or for driving primary inputs that can be reached directly. Internally it holds a maximal-length shift register with external feedback. Stage 1 receives the XOR of the stages selected by a tap-mask parameter, and every other stage takes the value of the stage before it. The vector is not read straight from the stages. Neighbouring stages are grouped into pairs (1 with 2, 3 with 4, and so on). When the last stage holds a one, the two members of every pair trade places on the way out.

Because the exchange is a one-to-one mapping for each value of the last stage, one period of the generator still visits every nonzero W-bit vector exactly once. Only the order changes. Each output still carries a balanced count of ones, and consecutive vectors differ in noticeably fewer bits than those of the plain register. A seed can be loaded at any time. A zero seed, which would lock up the register, is replaced by a nonzero default.

Top module: `bsw_pattern_gen`

## Requirements
- R1: After synchronous active-low reset the register holds SEED_DEFAULT (nonzero), so the vector equals the swapped image of SEED_DEFAULT (0x01 for the defaults).
- R2: With `load_i` high and a nonzero `seed_i`, the register holds `seed_i` after the next rising edge.
- R3: With `load_i` high and `seed_i` equal to zero, the register takes SEED_DEFAULT instead.
- R4: `load_i` takes priority over `enable_i` and works whether `enable_i` is high or low.
- R5: With `enable_i` and `load_i` both low, the register and `vec_o` keep their values.
- R6: With `enable_i` high and `load_i` low, stage k+1 (bit k) takes the old stage k (bit k-1), and stage 1 (bit 0) takes the XOR of the old stages whose TAP_MASK bit is set. Bit i of TAP_MASK stands for stage i+1.
- R7: Stage W (bit W-1) drives `vec_o[W-1]` unchanged and acts as the select. For each pair k below (W-1)/2, output bits 2k and 2k+1 equal stages bits 2k+1 and 2k when the select is 1, and equal them unswapped when it is 0. When W is even, bit W-2 passes through unchanged.
- R8: Starting from any nonzero state and running enabled, `vec_o` takes 2^W-1 distinct nonzero values, and the first value then repeats.
- R9: Over one full period, every output bit is one in exactly 2^(W-1) vectors.
- R10: Over one full period, counted cyclically, the total number of bit changes on `vec_o` is below 7/8 of the plain register's total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Advance the register by one step |
| load_i | input | 1 | Load the seed (has priority over enable) |
| seed_i | input | W | Seed value; zero selects SEED_DEFAULT |
| vec_o | output | W | Bit-swapped test vector |

## Verification
The assertions assume that TAP_MASK describes a primitive polynomial and that SEED_DEFAULT is nonzero. Under those two conditions the register can never reach the all-zero state, and the outputs never read as zero. They also assume that the control inputs are valid binary values at every clock edge once reset is released. The stimulus holds to these conditions. It keeps the default primitive mask, drives defined values on `enable_i`, `load_i` and `seed_i` on every cycle, and deliberately mixes zero seeds into the random loads so that the fallback path is exercised without ever breaking the nonzero-state assumption.

// File: rtl/bsw_pkg.sv
// Package: shared types for the bit-swapped pattern generator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bsw_pkg;

    // Register update selected for the coming clock edge.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_LOAD = 2'd2
    } step_e;

endpackage

// File: rtl/bsw_ctrl.sv
// Control decode: turns the enable and load inputs into one update step,
// with load taking priority. It also swaps a zero seed for the nonzero
// fallback. Assumes SEED_SAFE is nonzero.
module bsw_ctrl
    import bsw_pkg::*;
#(
    parameter int unsigned   W         = 7,
    parameter logic [W-1:0]  SEED_SAFE = 1
) (
    input  logic          enable_i,
    input  logic          load_i,
    input  logic [W-1:0]  seed_i,
    output step_e         step_o,
    output logic [W-1:0]  seed_eff_o
);

    // Priority decode of the requested step.
    always_comb begin
        if (load_i)        step_o = STEP_LOAD;
        else if (enable_i) step_o = STEP_ADV;
        else               step_o = STEP_HOLD;
    end

    // Replace an all-zero seed so the register cannot lock up.
    always_comb begin
        seed_eff_o = (seed_i == '0) ? SEED_SAFE : seed_i;
    end

endmodule

// File: rtl/bsw_lfsr_core.sv
// External-feedback shift register. Bit 0 is stage 1 and receives the XOR
// of the tap-masked stages; bit i takes bit i-1 on each advance. Assumes
// TAP_MASK is primitive for width W and that SEED_SAFE is nonzero.
module bsw_lfsr_core
    import bsw_pkg::*;
#(
    parameter int unsigned   W         = 7,
    parameter logic [W-1:0]  TAP_MASK  = 7'h41,
    parameter logic [W-1:0]  SEED_SAFE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_e         step_i,
    input  logic [W-1:0]  seed_i,
    output logic [W-1:0]  state_o
);

    logic [W-1:0] state_q;
    logic         fb;

    // Feedback bit: parity of the tapped stages.
    always_comb begin
        fb = ^(state_q & TAP_MASK);
    end

    // State register: reset, load, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED_SAFE;
        end else begin
            case (step_i)
                STEP_LOAD: state_q <= seed_i;
                STEP_ADV:  state_q <= {state_q[W-2:0], fb};
                default:   state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bsw_swap_net.sv
// Output swap network. The top stage drives every mux select. Each pair
// (2k, 2k+1) trades places when the select is 1. The top stage passes
// through, and for even W so does bit W-2. Assumes W >= 3.
module bsw_swap_net #(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] state_i,
    output logic [W-1:0] vec_o
);

    localparam int unsigned NPAIR = (W - 1) / 2;

    logic sel;
    assign sel = state_i[W-1];

    // One 2:1 mux pair per stage pair.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign vec_o[2*k]   = sel ? state_i[2*k+1] : state_i[2*k];
        assign vec_o[2*k+1] = sel ? state_i[2*k]   : state_i[2*k+1];
    end

    // Unpaired leftover stage for even widths.
    if ((W % 2) == 0) begin : g_odd_left
        assign vec_o[W-2] = state_i[W-2];
    end

    // Select stage passes straight through.
    assign vec_o[W-1] = state_i[W-1];

endmodule

// File: rtl/bsw_pattern_gen.sv
// Top level: bit-swapped exhaustive parallel pattern generator. It ties
// together the control decode, the shift register and the swap network.
// Assumes TAP_MASK is primitive for W, and W >= 3.
module bsw_pattern_gen
    import bsw_pkg::*;
#(
    parameter int unsigned   W            = 7,
    parameter logic [W-1:0]  TAP_MASK     = 7'h41,
    parameter logic [W-1:0]  SEED_DEFAULT = 7'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          load_i,
    input  logic [W-1:0]  seed_i,
    output logic [W-1:0]  vec_o
);

    localparam logic [W-1:0] SEED_SAFE =
        (SEED_DEFAULT == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED_DEFAULT;

    step_e        step;
    logic [W-1:0] seed_eff;
    logic [W-1:0] state_q;

    bsw_ctrl #(.W(W), .SEED_SAFE(SEED_SAFE)) ctrl_i (
        .enable_i   (enable_i),
        .load_i     (load_i),
        .seed_i     (seed_i),
        .step_o     (step),
        .seed_eff_o (seed_eff)
    );

    bsw_lfsr_core #(.W(W), .TAP_MASK(TAP_MASK), .SEED_SAFE(SEED_SAFE)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .seed_i  (seed_eff),
        .state_o (state_q)
    );

    bsw_swap_net #(.W(W)) swap_i (
        .state_i (state_q),
        .vec_o   (vec_o)
    );

endmodule

// File: rtl/bsw_pattern_gen_chk.sv
// Checker for bsw_pattern_gen: relates the ports and the register state
// across clock cycles. It is attached to every instance by the bind below.
module bsw_pattern_gen_chk #(
    parameter int unsigned   W         = 7,
    parameter logic [W-1:0]  SEED_SAFE = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable_i,
    input logic          load_i,
    input logic [W-1:0]  seed_i,
    input logic [W-1:0]  vec_o,
    input logic [W-1:0]  state
);

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !load_i) |=> ($stable(vec_o) && $stable(state))); // R5

    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (state == $past(seed_i))); // R2

    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (state == SEED_SAFE)); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !load_i) |=> (state[W-1:1] == $past(state[W-2:0]))); // R6

    AST_SWAP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(vec_o) == $countones(state)) && (vec_o[W-1] == state[W-1])); // R7

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o != '0); // R8

endmodule

bind bsw_pattern_gen bsw_pattern_gen_chk #(.W(W), .SEED_SAFE(SEED_SAFE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .load_i   (load_i),
    .seed_i   (seed_i),
    .vec_o    (vec_o),
    .state    (state_q)
);

// File: tb/bsw_pattern_gen_tb_top.sv
`timescale 1ns/1ps
// Bench for bsw_pattern_gen: directed corner cases followed by seeded random
// control traffic, all checked against a bench-side model written from the
// requirements.
module bsw_pattern_gen_tb_top;

    localparam int unsigned  W    = 7;
    localparam logic [W-1:0] TAPS = 7'h41;
    localparam logic [W-1:0] DSEED = 7'h01;
    localparam int unsigned  PER  = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable_i;
    logic          load_i;
    logic [W-1:0]  seed_i;
    logic [W-1:0]  vec_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [W-1:0] model;

    always #2 clk = ~clk;

    bsw_pattern_gen #(.W(W), .TAP_MASK(TAPS), .SEED_DEFAULT(DSEED)) dut_i (
        .clk (clk), .rst_n (rst_n), .enable_i (enable_i),
        .load_i (load_i), .seed_i (seed_i), .vec_o (vec_o)
    );

    // Plain register advance per R6.
    function automatic logic [W-1:0] adv(input logic [W-1:0] s);
        logic f = 1'b0;
        for (int i = 0; i < W; i++) if (TAPS[i]) f ^= s[i];
        return {s[W-2:0], f};
    endfunction

    // Output mapping per R7.
    function automatic logic [W-1:0] swp(input logic [W-1:0] s);
        logic [W-1:0] v = s;
        if (s[W-1]) for (int k = 0; k < (W-1)/2; k++) begin
            v[2*k]   = s[2*k+1];
            v[2*k+1] = s[2*k];
        end
        return v;
    endfunction

    function automatic int hd(input logic [W-1:0] a, input logic [W-1:0] b);
        return $countones(a ^ b);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the negedge, step the model, check at the next negedge.
    task automatic cyc(input bit en, input bit ld, input logic [W-1:0] sd, input string req);
        enable_i = en; load_i = ld; seed_i = sd;
        if (ld) model = (sd == '0) ? DSEED : sd;
        else if (en) model = adv(model);
        @(negedge clk);
        chk(vec_o == swp(model), req, int'(vec_o), int'(swp(model)));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R8: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v0, first, prev_v, prev_s;
        bit seen [0:PER];
        int ones [W];
        int tr_dut, tr_plain;
        void'($urandom(32'h1c0ffee5));
        rst_n = 1'b0; enable_i = 1'b0; load_i = 1'b0; seed_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = DSEED;
        chk(vec_o == 7'h01, "R1", int'(vec_o), 1);

        // R3 and R4: zero seed with enable low still loads the default.
        cyc(1, 0, '0, "R6");
        cyc(1, 0, '0, "R6");
        cyc(0, 1, '0, "R3");
        chk(vec_o == swp(DSEED), "R4", int'(vec_o), int'(swp(DSEED)));
        // R2 and R4: load wins over enable.
        cyc(1, 1, 7'h5a, "R2");
        cyc(0, 1, 7'h33, "R4");
        // R7: select set, pairs swapped: 1000001 -> 1000010.
        cyc(0, 1, 7'h41, "R7");
        chk(vec_o == 7'h42, "R7", int'(vec_o), 'h42);
        // R5: hold with random seed on the pins.
        v0 = vec_o;
        for (int i = 0; i < 5; i++) begin
            cyc(0, 0, 7'($urandom), "R5");
            chk(vec_o == v0, "R5", int'(vec_o), int'(v0));
        end

        // Random mix of enable, load and seeds (including zero).
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] sd = 7'($urandom);
            if ($urandom_range(3) == 0) sd = '0;
            cyc($urandom_range(3) != 0, $urandom_range(15) == 0, sd, "R6");
        end

        // Full period from a loaded seed: R8, R9, R10.
        cyc(0, 1, 7'h2b, "R2");
        for (int i = 0; i <= PER; i++) seen[i] = 1'b0;
        for (int b = 0; b < W; b++) ones[b] = 0;
        tr_dut = 0; tr_plain = 0;
        first = vec_o; prev_v = vec_o; prev_s = model;
        for (int i = 0; i < PER; i++) begin
            if (i > 0) begin
                cyc(1, 0, '0, "R8");
                tr_dut += hd(prev_v, vec_o);
                tr_plain += hd(prev_s, model);
                prev_v = vec_o; prev_s = model;
            end
            chk(!seen[vec_o] && vec_o != '0, "R8", int'(vec_o), 0);
            seen[vec_o] = 1'b1;
            for (int b = 0; b < W; b++) ones[b] += int'(vec_o[b]);
        end
        cyc(1, 0, '0, "R8");
        tr_dut += hd(prev_v, vec_o);
        tr_plain += hd(prev_s, model);
        chk(vec_o == first, "R8", int'(vec_o), int'(first));
        for (int b = 0; b < W; b++)
            chk(ones[b] == (1 << (W-1)), "R9", ones[b], 1 << (W-1));
        chk(tr_plain == W * (1 << (W-1)), "R10", tr_plain, W * (1 << (W-1)));
        chk(tr_dut * 8 < tr_plain * 7, "R10", tr_dut, (tr_plain * 7) / 8);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule